// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between a simple request/acknowledge host port and an external asynchronous 32K x 8 static RAM. The host presents a 15-bit word address, a direction bit and a write byte, and holds `req` high until a single-cycle `ack` returns. The controller then plays out one complete memory cycle on the active-low chip select, write enable and output enable strobes. It splits the bidirectional data bus into an outgoing byte, an incoming byte and an enable for an external tristate driver.

Every analogue limit of the memory is given in nanoseconds as a parameter. Each limit is turned into a whole number of system clock cycles by rounding up against `CLK_PERIOD_NS`, and every phase lasts at least one cycle. Writes wait for the memory to release the bus before the controller drives it. Reads sample the returned byte on the last edge of the access window, before the strobes are withdrawn. After each access the controller returns to idle. It accepts a new request only there, and only once the previous acknowledge has gone.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are high, and `sram_dq_oe` and `ack` are low.
- R2: Each write request yields exactly one write pulse. During that pulse `sram_we_n` stays low for at least ceil(45 ns / period) cycles and `sram_cs_n` stays low. `sram_addr` does not change while `sram_cs_n` is low.
- R3: The controller never drives the bus while the memory may drive it. `sram_dq_oe` is never high while `sram_oe_n` is low. It rises only after `sram_we_n` has been low for at least one cycle. It stays low for ceil(20 ns / period) cycles after the memory last drove.
- R4: Write data is driven, and `sram_dq_out` is held, for at least ceil(35 ns / period) cycles before `sram_we_n` rises. It is still driven in the cycle after the rise, which gives zero hold.
- R5: `sram_we_n` is low only while `sram_cs_n` is low and `sram_oe_n` is high. `sram_oe_n` is low only while `sram_cs_n` is low and `sram_we_n` is high.
- R6: A read returns the byte last written to that address, or 0 for a word never written. The byte is sampled on the last clock edge of a window of at least ceil(50 ns / period) cycles from address and chip select, and ceil(20 ns / period) cycles from output enable.
- R7: `rdata` changes only on the clock edge that ends a cycle with `sram_oe_n` low, which is the end of a read's access window. It holds its value through later writes and idle time.
- R8: Between write pulses `sram_we_n` stays high for at least ceil(5 ns / period) cycles. Successive falls of `sram_we_n` are at least ceil(50 ns / period) cycles apart.
- R9: `ack` is high for exactly one cycle per request. A request is taken only in idle with `ack` low, so a `req` held through the `ack` cycle starts no second access.
- R10: All 15 address bits reach the memory unchanged. Addresses 0x0000, 0x4000 and 0x7FFF hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Host request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Host word address |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Last byte read |
| ack | output | 1 | One-cycle completion pulse |
| sram_addr | output | 15 | Memory address |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | 8 | Byte toward the memory |
| sram_dq_in | input | 8 | Byte from the memory |
| sram_dq_oe | output | 1 | Enable for the external data driver |

## Verification
The hardest case to reach from the ports is a write that follows a read directly, while the memory is still letting go of the bus. Two others are a `req` left high across the `ack` edge and an access-window count that is one cycle short. A timing-aware memory model answers with the inverted byte unless its access windows are met. It records any cycle in which both sides could drive the bus. Random sequences from a fixed seed mix reads and writes over a small address pool, so read-then-write pairs occur often. Directed cases cover the corner addresses, back-to-back writes, `rdata` holding across writes, and a held request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WWAITZ,
    ST_WDRIVE,
    ST_WRECOV,
    ST_RSETUP,
    ST_RACCESS,
    ST_RRELEASE
  } ctrl_state_t;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_nx = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int SETUP_C = 1,
  parameter int WZ_C    = 2,
  parameter int DRV_C   = 4,
  parameter int REC_C   = 1,
  parameter int ACC_C   = 4,
  parameter int REL_C   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             tzero,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ack,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  ctrl_state_t state_q;
  ctrl_state_t state_nx;
  logic        ack_nx;
  logic        cs_n_nx;
  logic        we_n_nx;
  logic        oe_n_nx;
  logic        dq_oe_nx;

  // next-state logic
  always_comb begin
    state_nx = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req && !ack) begin
          accept   = 1'b1;
          state_nx = we ? ST_WSETUP : ST_RSETUP;
        end
      end
      ST_WSETUP:   if (tzero) state_nx = ST_WWAITZ;
      ST_WWAITZ:   if (tzero) state_nx = ST_WDRIVE;
      ST_WDRIVE:   if (tzero) state_nx = ST_WRECOV;
      ST_WRECOV:   if (tzero) state_nx = ST_IDLE;
      ST_RSETUP:   if (tzero) state_nx = ST_RACCESS;
      ST_RACCESS: begin
        if (tzero) begin
          capture  = 1'b1;
          state_nx = ST_RRELEASE;
        end
      end
      ST_RRELEASE: if (tzero) state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  // phase length loaded on every state entry
  always_comb begin
    load = (state_nx != state_q);
    unique case (state_nx)
      ST_WSETUP,
      ST_RSETUP:   load_val = CNT_W'(SETUP_C - 1);
      ST_WWAITZ:   load_val = CNT_W'(WZ_C - 1);
      ST_WDRIVE:   load_val = CNT_W'(DRV_C - 1);
      ST_WRECOV:   load_val = CNT_W'(REC_C - 1);
      ST_RACCESS:  load_val = CNT_W'(ACC_C - 1);
      ST_RRELEASE: load_val = CNT_W'(REL_C - 1);
      default:     load_val = '0;
    endcase
  end

  // strobes decoded from the next state so they leave registers
  always_comb begin
    ack_nx   = (state_nx == ST_IDLE) && (state_q != ST_IDLE);
    cs_n_nx  = (state_nx == ST_IDLE) || (state_nx == ST_WRECOV) ||
               (state_nx == ST_RRELEASE);
    we_n_nx  = !((state_nx == ST_WWAITZ) || (state_nx == ST_WDRIVE));
    oe_n_nx  = (state_nx != ST_RACCESS);
    dq_oe_nx = (state_nx == ST_WDRIVE) || (state_nx == ST_WRECOV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack     <= 1'b0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_nx;
      ack     <= ack_nx;
      cs_n    <= cs_n_nx;
      we_n    <= we_n_nx;
      oe_n    <= oe_n_nx;
      dq_oe   <= dq_oe_nx;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      dq_out    <= '0;
    end else if (accept) begin
      sram_addr <= addr;
      dq_out    <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 45,
  parameter int T_DS_NS       = 35,
  parameter int T_WZ_NS       = 15,
  parameter int T_WGAP_NS     = 5,
  parameter int T_WC_NS       = 50,
  parameter int T_AA_NS       = 50,
  parameter int T_ACS_NS      = 50,
  parameter int T_OE_NS       = 20,
  parameter int T_OHZ_NS      = 15,
  parameter int T_CHZ_NS      = 20,
  parameter int T_RC_NS       = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int P       = CLK_PERIOD_NS;
  localparam int SETUP_C = imax(1, ns2cyc(T_AS_NS, P));
  localparam int WZ_C    = imax(1, ns2cyc(T_WZ_NS, P));
  localparam int DRV_C   = imax(1, imax(ns2cyc(T_DS_NS, P),
                                        ns2cyc(T_WP_NS, P) - WZ_C));
  localparam int REC_C   = imax(1, imax(ns2cyc(T_WGAP_NS, P),
                                        ns2cyc(T_WC_NS, P) - SETUP_C - WZ_C - DRV_C));
  localparam int ACC_C   = imax(1, imax(ns2cyc(T_OE_NS, P),
                                        imax(ns2cyc(T_AA_NS, P), ns2cyc(T_ACS_NS, P)) - SETUP_C));
  localparam int REL_C   = imax(1, imax(imax(ns2cyc(T_CHZ_NS, P), ns2cyc(T_OHZ_NS, P)),
                                        ns2cyc(T_RC_NS, P) - SETUP_C - ACC_C));
  localparam int MAX_C   = imax(imax(imax(SETUP_C, WZ_C), imax(DRV_C, REC_C)),
                                imax(ACC_C, REL_C));
  localparam int CNT_W   = imax(1, $clog2(MAX_C));

  logic             rst_n_int;
  logic             tzero;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             accept;
  logic             capture;

  sram_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load),
    .load_val (load_val),
    .zero     (tzero)
  );

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .SETUP_C (SETUP_C),
    .WZ_C    (WZ_C),
    .DRV_C   (DRV_C),
    .REC_C   (REC_C),
    .ACC_C   (ACC_C),
    .REL_C   (REL_C)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req      (req),
    .we       (we),
    .tzero    (tzero),
    .load     (load),
    .load_val (load_val),
    .accept   (accept),
    .capture  (capture),
    .ack      (ack),
    .cs_n     (sram_cs_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .accept    (accept),
    .capture   (capture),
    .addr      (addr),
    .wdata     (wdata),
    .dq_in     (sram_dq_in),
    .sram_addr (sram_addr),
    .dq_out    (sram_dq_out),
    .rdata     (rdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WP_NS       = 45
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  localparam int WP_C = ns2cyc(T_WP_NS, CLK_PERIOD_NS);

  logic [15:0] we_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_run <= '0;
    end else if (sram_we_n) begin
      we_low_run <= '0;
    end else if (we_low_run != 16'hFFFF) begin
      we_low_run <= we_low_run + 16'd1;
    end
  end

  p_wp_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (int'(we_low_run) >= WP_C));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_drive_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  p_we_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_oe_n));

  p_oe_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_cs_n && sram_we_n));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(!sram_oe_n));

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WP_NS       (T_WP_NS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .rdata      (rdata),
  .sram_addr  (sram_addr),
  .sram_cs_n  (sram_cs_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int TB_CLK_NS = 10;
  localparam int WATCHDOG  = 150000;
  // memory limits, rounded up to whole cycles by the bench itself
  localparam int WP_MIN    = (45 + TB_CLK_NS - 1) / TB_CLK_NS;
  localparam int DS_MIN    = (35 + TB_CLK_NS - 1) / TB_CLK_NS;
  localparam int GAP_MIN   = (5 + TB_CLK_NS - 1) / TB_CLK_NS;
  localparam int WC_MIN    = (50 + TB_CLK_NS - 1) / TB_CLK_NS;
  localparam int RELEASE   = (20 + TB_CLK_NS - 1) / TB_CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ack;
  logic [14:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in;

  int n_cmp = 0;
  int n_bad = 0;

  always #(TB_CLK_NS / 2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(TB_CLK_NS)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .we          (we),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .ack         (ack),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_in  (sram_dq_in),
    .sram_dq_oe  (sram_dq_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- timing-aware memory model ----------------
  logic [7:0] model_mem [int unsigned];
  logic [7:0] exp_mem   [int unsigned];
  int  we_run, drv_run, we_high_run, since_fall, addr_run, oe_run, tail;
  int  writes_seen = 0;
  int  cs_falls = 0;
  bit  had_write;
  logic prev_we_n, prev_oe_n, prev_cs_n;
  logic [14:0] prev_addr;

  function automatic logic [7:0] model_rd(input logic [14:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [14:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      we_run = 0; drv_run = 0; we_high_run = 0; since_fall = 0;
      addr_run = 0; oe_run = 0; tail = 0; had_write = 1'b0;
      prev_we_n = 1'b1; prev_oe_n = 1'b1; prev_cs_n = 1'b1; prev_addr = '0;
      sram_dq_in <= 8'h00;
    end else begin
      automatic bit mem_drv = !sram_cs_n && !sram_oe_n && sram_we_n;
      // R3: both sides on the bus
      if (sram_dq_oe && (mem_drv || tail > 0))
        check(1'b0, "R3 bus contention", int'(sram_dq_oe), 0);
      if (mem_drv) tail = RELEASE;
      else if (tail > 0) tail--;
      if (prev_cs_n && !sram_cs_n) cs_falls++;
      since_fall++;
      // write start
      if (prev_we_n && !sram_we_n) begin
        check(!sram_cs_n && sram_oe_n, "R5 write strobes", {sram_cs_n, sram_oe_n}, 1);
        if (had_write) begin
          check(we_high_run >= GAP_MIN, "R8 we high gap", we_high_run, GAP_MIN);
          check(since_fall >= WC_MIN, "R8 write cycle", since_fall, WC_MIN);
        end
        since_fall = 0;
      end
      if (!sram_we_n) begin
        we_high_run = 0;
        if (!sram_cs_n) we_run++;
        if (sram_dq_oe) drv_run++;
      end else begin
        we_high_run++;
        if (!prev_we_n) begin
          check(we_run >= WP_MIN, "R2 write pulse width", we_run, WP_MIN);
          check(drv_run >= DS_MIN, "R4 data setup", drv_run, DS_MIN);
          check(sram_dq_oe == 1'b1, "R4 data hold", int'(sram_dq_oe), 1);
          model_mem[int'(sram_addr)] = sram_dq_out;
          writes_seen++;
          had_write = 1'b1;
          we_run = 0; drv_run = 0;
        end
      end
      // read side
      if (prev_oe_n && !sram_oe_n)
        check(!sram_cs_n && sram_we_n, "R5 read strobes", {sram_cs_n, sram_we_n}, 1);
      if (sram_cs_n) addr_run = 0;
      else if (!prev_cs_n && sram_addr == prev_addr) addr_run++;
      else addr_run = 1;
      if (!sram_oe_n && !sram_cs_n) oe_run++;
      else oe_run = 0;
      if (mem_drv && addr_run * TB_CLK_NS >= 50 && oe_run * TB_CLK_NS >= 20)
        sram_dq_in <= model_rd(sram_addr);
      else
        sram_dq_in <= ~model_rd(sram_addr);
      prev_we_n = sram_we_n; prev_oe_n = sram_oe_n;
      prev_cs_n = sram_cs_n; prev_addr = sram_addr;
    end
  end

  // ---------------- host tasks ----------------
  task automatic host_access(input bit w, input logic [14:0] a, input logic [7:0] d,
                             input bit hold_req);
    int lat;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 100);
    check(ack == 1'b1, "R9 ack returned", lat, 0);
    if (!hold_req) req = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R9 ack one cycle", int'(ack), 0);
    req = 1'b0;
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int w0 = writes_seen;
    host_access(1'b1, a, d, 1'b0);
    check(writes_seen == w0 + 1, "R2 one pulse per write", writes_seen - w0, 1);
    exp_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [14:0] a, input string tag);
    host_access(1'b0, a, 8'h00, 1'b0);
    check(rdata == exp_rd(a), tag, int'(rdata), int'(exp_rd(a)));
  endtask

  function automatic logic [14:0] pool_addr(input int k);
    logic [4:0] kk = k[4:0];
    return {kk, 5'b00000, kk};
  endfunction

  task automatic check_idle(input string tag);
    check({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack} == 5'b11100, tag,
          int'({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack}), 'h1c);
  endtask

  task automatic run_all();
    logic [7:0] held;
    int f0;
    void'($urandom(32'd7421));
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_idle("R1 after reset");

    // R10 corner addresses
    do_write(15'h0000, 8'h3C);
    do_write(15'h7FFF, 8'hC3);
    do_write(15'h4000, 8'h5A);
    do_read(15'h0000, "R10 addr 0000");
    do_read(15'h7FFF, "R10 addr 7FFF");
    do_read(15'h4000, "R10 addr 4000");
    do_read(15'h1234, "R6 unwritten word");

    // back-to-back writes then read (R8)
    do_write(15'h0101, 8'h11);
    do_write(15'h0101, 8'h22);
    do_read(15'h0101, "R6 last write wins");

    // R7 rdata held across a write to another word
    do_read(15'h7FFF, "R6 read before hold");
    held = rdata;
    do_write(15'h0202, 8'h99);
    repeat (4) @(negedge clk);
    check(rdata == held, "R7 rdata held", int'(rdata), int'(held));

    // R9 req held through the ack edge starts nothing new
    f0 = cs_falls;
    host_access(1'b0, 15'h0000, 8'h00, 1'b1);
    repeat (12) @(negedge clk);
    check(cs_falls == f0 + 1, "R9 held req single access", cs_falls - f0, 1);
    check(rdata == exp_rd(15'h0000), "R6 held req read", int'(rdata), int'(exp_rd(15'h0000)));

    // random mix over a small pool, read right after write often
    for (int i = 0; i < 300; i++) begin
      automatic logic [14:0] a = pool_addr($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 0) do_write(a, 8'($urandom));
      else do_read(a, "R6 random read");
    end
    for (int k = 0; k < 32; k++) do_read(pool_addr(k), "R6 final sweep");
    check_idle("R1 idle at end");
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule